// File: doc/BRIEF.md
# Alternating Valley Switching Selector

This block sits in the turn-on path of a quasi-resonant flyback controller. After the blanking interval that follows each gate turn-on, the drain ringing produces a series of valley events. The block decides which of those valleys triggers the next turn-on. By default it uses the first valley. While a frequency-spreading mode is engaged, it alternates between two cycles on the first valley and two cycles on the second valley. This moves the switching frequency between two values and spreads conducted noise.

A free-running pair counter counts gate turn-on pulses and flips a phase bit after every `PAIR_LEN` pulses. Trigger and de-trigger pulses from outside the block engage and release the mode. The trigger means high input voltage with a short on-time. The selected valley index is registered and exposed as a status output. A forced turn-on pulse from the surrounding timer takes over if the selected valley has not arrived.

Top module: `avs_valley_sel`

## Requirements
- R1: After synchronous reset, `turn_on_o` is 0 and `valley_sel_o` is 1.
- R2: The phase flips after every second gate pulse (`PAIR_LEN` = 2). It counts every `gate_on_i` pulse whether or not the mode is engaged and whatever the valley, force, trigger and de-trigger inputs do.
- R3: While the mode is engaged, `valley_sel_o` is 1 (first valley) in phase 0 and 2 (second valley) in phase 1. With the default pair length this gives two cycles on the first valley, then two on the second, repeating.
- R4: A `trig_i` pulse engages the mode and a `detrig_i` pulse releases it. If both arrive in the same cycle, the de-trigger wins. `valley_sel_o` follows the mode state one clock after the mode register changes.
- R5: While the mode is released, `valley_sel_o` is 1.
- R6: The pair counter keeps running while the mode is released. The valley chosen right after a trigger therefore depends on how many gate pulses have occurred since reset, not on when the trigger came.
- R7: Valley pulses that arrive after a gate pulse but before `blank_end_i` are not counted.
- R8: After `blank_end_i`, the valley pulse whose count equals `valley_sel_o` raises `turn_on_o` for exactly one cycle, on the clock edge that samples that valley.
- R9: `force_on_i` raises `turn_on_o` on the next edge if it arrives while the block waits for a valley. It has no effect during blanking or after a turn-on has already been issued.
- R10: At most one turn-on is issued per switching cycle. Further valleys or forces are ignored until the next `gate_on_i`.
- R11: Each `gate_on_i` clears the valley count, so every switching cycle counts valleys from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on_i | input | 1 | One-cycle pulse at each gate turn-on |
| blank_end_i | input | 1 | One-cycle pulse when the blanking interval ends |
| valley_i | input | 1 | One-cycle pulse per detected resonant valley |
| force_on_i | input | 1 | One-cycle pulse forcing turn-on at the end of the detection window |
| trig_i | input | 1 | Pulse engaging the alternating mode |
| detrig_i | input | 1 | Pulse releasing the alternating mode |
| turn_on_o | output | 1 | Registered one-cycle turn-on request |
| valley_sel_o | output | IDX_W (2) | Registered index of the selected valley (1 or 2) |

## Verification
The hardest situation to reach is a trigger that lands in the middle of a pair while the counter is in phase 1. Only then does the first switching cycle after engagement use the second valley. The stimulus runs an odd number of gate pulses with the mode released before it triggers. Constrained random switching cycles then mix valley counts, forced turn-ons, and trigger and de-trigger pulses at random points, including both in one cycle. A bench model predicts the turn-on cycle and the selected index in every cycle.

// File: rtl/avs_pkg.sv
package avs_pkg;

  typedef enum logic [1:0] {
    TRK_WAIT  = 2'd0,
    TRK_BLANK = 2'd1,
    TRK_HUNT  = 2'd2
  } trk_state_e;

endpackage

// File: rtl/avs_pair_cnt.sv
module avs_pair_cnt #(
  parameter int PAIR_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on_i,
  output logic phase_o
);

  localparam int PCW = (PAIR_LEN > 1) ? $clog2(PAIR_LEN) : 1;
  localparam logic [PCW-1:0] LAST = PCW'(PAIR_LEN - 1);

  logic [PCW-1:0] cnt_q;
  logic           phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (gate_on_i) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + PCW'(1);
      end
    end
  end

  assign phase_o = phase_q;

  // R2: the phase only moves on a gate pulse
  assert_phase_gate_only_R2: assert property (@(posedge clk) disable iff (rst)
    !gate_on_i |=> $stable(phase_q));

endmodule

// File: rtl/avs_mode_ctl.sv
module avs_mode_ctl (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic detrig_i,
  output logic active_o
);

  logic active_q;

  always_ff @(posedge clk) begin
    if (rst)           active_q <= 1'b0;
    else if (detrig_i) active_q <= 1'b0;
    else if (trig_i)   active_q <= 1'b1;
  end

  assign active_o = active_q;

  // R4: a de-trigger always releases the mode, even beside a trigger
  assert_detrig_wins_R4: assert property (@(posedge clk) disable iff (rst)
    detrig_i |=> !active_q);

  // R4: a lone trigger engages the mode
  assert_trig_engages_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !detrig_i) |=> active_q);

endmodule

// File: rtl/avs_valley_trk.sv
module avs_valley_trk
  import avs_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_on_i,
  input  logic             blank_end_i,
  input  logic             valley_i,
  input  logic             force_on_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic             turn_on_o
);

  localparam int CW = IDX_W + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  trk_state_e     st_q;
  trk_state_e     st_d;
  logic [CW-1:0]  vcnt_q;
  logic [CW-1:0]  vcnt_d;
  logic [CW-1:0]  vcnt_inc;
  logic           hit_valley;
  logic           fire;
  logic           turn_q;

  always_comb begin
    vcnt_inc   = (vcnt_q == CMAX) ? vcnt_q : vcnt_q + CW'(1);
    hit_valley = valley_i && (vcnt_inc == {1'b0, sel_i});
    fire       = (st_q == TRK_HUNT) && (hit_valley || force_on_i);
  end

  always_comb begin
    st_d   = st_q;
    vcnt_d = vcnt_q;
    if (gate_on_i) begin
      st_d   = TRK_BLANK;
      vcnt_d = '0;
    end else begin
      unique case (st_q)
        TRK_BLANK: if (blank_end_i) st_d = TRK_HUNT;
        TRK_HUNT: begin
          if (valley_i) vcnt_d = vcnt_inc;
          if (fire) st_d = TRK_WAIT;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TRK_WAIT;
      vcnt_q <= '0;
      turn_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      vcnt_q <= vcnt_d;
      turn_q <= fire;
    end
  end

  assign turn_on_o = turn_q;

  // R10: a turn-on request lasts a single cycle
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    turn_q |=> !turn_q);

  // R7: nothing fires outside the valley hunt
  assert_no_fire_outside_hunt_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q != TRK_HUNT) |=> !turn_q);

  // R11: a gate pulse restarts counting from zero
  assert_count_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    gate_on_i |=> (vcnt_q == '0));

endmodule

// File: rtl/avs_valley_sel.sv
module avs_valley_sel #(
  parameter int PAIR_LEN = 2,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_on_i,
  input  logic             blank_end_i,
  input  logic             valley_i,
  input  logic             force_on_i,
  input  logic             trig_i,
  input  logic             detrig_i,
  output logic             turn_on_o,
  output logic [IDX_W-1:0] valley_sel_o
);

  localparam logic [IDX_W-1:0] IDX_FIRST  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_SECOND = IDX_W'(2);

  logic             phase;
  logic             active;
  logic [IDX_W-1:0] sel_q;

  avs_pair_cnt #(.PAIR_LEN(PAIR_LEN)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .gate_on_i (gate_on_i),
    .phase_o   (phase)
  );

  avs_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig_i),
    .detrig_i (detrig_i),
    .active_o (active)
  );

  always_ff @(posedge clk) begin
    if (rst)                  sel_q <= IDX_FIRST;
    else if (active && phase) sel_q <= IDX_SECOND;
    else                      sel_q <= IDX_FIRST;
  end

  assign valley_sel_o = sel_q;

  avs_valley_trk #(.IDX_W(IDX_W)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .gate_on_i   (gate_on_i),
    .blank_end_i (blank_end_i),
    .valley_i    (valley_i),
    .force_on_i  (force_on_i),
    .sel_i       (sel_q),
    .turn_on_o   (turn_on_o)
  );

  // R5: a released mode selects the first valley
  assert_idle_first_R5: assert property (@(posedge clk) disable iff (rst)
    !active |=> (valley_sel_o == IDX_FIRST));

  // R3: only index 1 or 2 is ever selected
  assert_sel_range_R3: assert property (@(posedge clk) disable iff (rst)
    (valley_sel_o == IDX_FIRST) || (valley_sel_o == IDX_SECOND));

endmodule

// File: tb/avs_valley_sel_test.sv
module avs_valley_sel_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       gate_on_i, blank_end_i, valley_i, force_on_i, trig_i, detrig_i;
  logic       turn_on_o;
  logic [1:0] valley_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  int m_st;    // 0 wait, 1 blank, 2 hunt
  int m_cnt;
  int m_g;
  bit m_act;
  int m_sel;
  bit m_fire;

  always #2 clk = ~clk;

  avs_valley_sel uut (
    .clk(clk), .rst(rst), .gate_on_i(gate_on_i), .blank_end_i(blank_end_i),
    .valley_i(valley_i), .force_on_i(force_on_i), .trig_i(trig_i),
    .detrig_i(detrig_i), .turn_on_o(turn_on_o), .valley_sel_o(valley_sel_o)
  );

  task automatic check(input string tag, input int act, input int exp_v, input string what);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  function automatic int exp_sel(input bit act, input int g);
    return (act && (((g / 2) % 2) == 1)) ? 2 : 1;
  endfunction

  task automatic step(input bit g, input bit b, input bit v, input bit f,
                      input bit t, input bit d, input string tag);
    int nsel;
    @(negedge clk);
    gate_on_i = g; blank_end_i = b; valley_i = v;
    force_on_i = f; trig_i = t; detrig_i = d;
    m_fire = (m_st == 2) && ((v && (m_cnt + 1 == m_sel)) || f);
    nsel   = exp_sel(m_act, m_g);
    if (g) begin
      m_st = 1; m_cnt = 0;
    end else if (m_st == 1 && b) begin
      m_st = 2;
    end else if (m_st == 2) begin
      if (v) m_cnt++;
      if (m_fire) m_st = 0;
    end
    if (g) m_g++;
    if (d) m_act = 0;
    else if (t) m_act = 1;
    m_sel = nsel;
    @(posedge clk);
    #1;
    check(tag, turn_on_o, m_fire, "turn_on_o");
    check(tag, valley_sel_o, m_sel, "valley_sel_o");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // one switching cycle: gate, blanking with a stray valley, then valleys
  task automatic sw_cycle(input int nval, input bit frc, input string tag);
    step(1, 0, 0, 0, 0, 0, tag);
    step(0, 0, 1, 0, 0, 0, "R7");
    idle(1, tag);
    step(0, 1, 0, 0, 0, 0, tag);
    for (int i = 0; i < nval; i++) begin
      idle(1, tag);
      step(0, 0, 1, 0, 0, 0, tag);
    end
    if (frc) step(0, 0, 0, 1, 0, 0, "R9");
    idle(1, tag);
  endtask

  initial begin
    int rs;
    gate_on_i = 0; blank_end_i = 0; valley_i = 0;
    force_on_i = 0; trig_i = 0; detrig_i = 0;
    rst = 1;
    m_st = 0; m_cnt = 0; m_g = 0; m_act = 0; m_sel = 1; m_fire = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", turn_on_o, 0, "turn_on_o");
    check("R1", valley_sel_o, 1, "valley_sel_o");
    @(negedge clk);
    rst = 0;

    // R5: released mode, first valley each cycle; 3 gate pulses leave phase 1
    sw_cycle(2, 0, "R5");
    sw_cycle(1, 0, "R8");
    sw_cycle(0, 1, "R9");
    // R6: trigger mid-pair, phase already 1 -> second valley selected
    step(0, 0, 0, 0, 1, 0, "R6");
    idle(1, "R6");
    check("R6", valley_sel_o, 2, "valley_sel_o after mid-pair trigger");
    sw_cycle(2, 0, "R6");
    // R3: alternation pattern over several cycles, extra valleys ignored (R10)
    for (int i = 0; i < 6; i++) sw_cycle(3, 1, "R3");
    sw_cycle(3, 1, "R10");
    // R11: count from zero each cycle with a single valley (second never reached)
    sw_cycle(1, 1, "R11");
    // R4: simultaneous trigger and de-trigger releases
    step(0, 0, 0, 0, 1, 1, "R4");
    idle(2, "R4");
    check("R4", valley_sel_o, 1, "valley_sel_o after both pulses");
    // R9: force in blanking ignored, force after turn-on ignored
    step(1, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 0, "R9");
    step(0, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, "R9");
    idle(1, "R9");

    // constrained random cycles
    rs = $urandom(32'h5EED_A1F0);
    for (int c = 0; c < 400; c++) begin
      bit g, b, v, f, t, d;
      g = ($urandom % 12) == 0;
      b = ($urandom % 4) == 0;
      v = ($urandom % 3) == 0;
      f = ($urandom % 10) == 0;
      t = ($urandom % 20) == 0;
      d = ($urandom % 30) == 0;
      step(g, b, v, f, t, d, "R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule